// File: doc/BRIEF.md
# Self-Timed Transposed FIR Filter

This block filters a stream of 8-bit unsigned samples with a fixed set of unsigned 8-bit weights that are set at elaboration. It is built in transposed form. A row of tap stages is joined by single-entry buffers. Each buffer holds one word and a full flag, and uses a valid/ready handshake on both of its sides. No central controller sequences the taps. Each tap advances only when its neighbours' buffers allow it.

A sample enters through a valid/ready input and is copied into one sample buffer per tap. Each tap first takes a partial sum from the buffer on its upstream side. It then takes its sample, multiplies the sample by its weight, adds the partial sum, and writes the total into the buffer on its downstream side. At reset, every interior partial-sum buffer holds zero, so the filter starts as if all earlier samples were zero. The head buffer refills itself with zero each time it is emptied. The 32-bit result leaves through a valid/ready output that is driven straight from the last buffer's registers.

Top module: `tfir_chain`

## Requirements
- R1: After reset is released, `m_valid` is 0 and `s_ready` is 1.
- R2: The n-th result equals the sum over k of `COEF[k]` times x[n-k], wrapped to 32 bits. Samples and weights are unsigned, and `COEF[0]` weights the newest sample.
- R3: Samples before the first one accepted after reset count as zero. An impulse of value 1 followed by zeros therefore yields `COEF[0]`, `COEF[1]` and so on, in that order.
- R4: When the filter is idle and the output is empty, the result for an accepted sample shows on `m_valid` in the cycle after the accepting edge.
- R5: In the cycle after a sample is accepted, `s_ready` is 0. Under a continuous input with the output always ready, exactly one sample is accepted every two cycles.
- R6: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` does not change. When every buffer is full, `s_ready` stays 0.
- R7: Under random output backpressure, results leave in input order, with none lost and none repeated.
- R8: In the cycle after an output transfer, `m_valid` is 0, because a buffer cannot be refilled in the cycle it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | All sample buffers are empty, so a sample can be taken |
| s_data | input | SAMPLE_W | Unsigned input sample |
| m_valid | output | 1 | The output buffer is full |
| m_ready | input | 1 | The consumer takes the result |
| m_data | output | ACC_W | Signed filter result |

## Verification
From an idle state, an accepted sample's result is due one edge after the accepting edge. The bench checks this at the two falling edges that bracket that edge. Everywhere else the timing depends on backpressure, so a scoreboard does the checking. The driver pushes the reference sum when it sees `s_ready` high together with its own valid. The monitor pops and compares at each falling edge where `m_valid` and `m_ready` are both high, which is exactly where a transfer is decided. The two-cycle input rate is checked by counting acceptances over a fixed window. The hold rule is checked by sampling `m_data` over several stalled cycles.

// File: rtl/tfir_pkg.sv
package tfir_pkg;
  localparam int SAMPLE_W_DEF = 8;
  localparam int COEF_W_DEF   = 8;
  localparam int ACC_W_DEF    = 32;
endpackage

// File: rtl/tfir_slot.sv
// Single-entry buffer: accepts a write only when empty, a read only when full.
module tfir_slot #(
  parameter int         W         = 32,
  parameter bit         INIT_FULL = 1'b0,
  parameter logic [W-1:0] INIT_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_ready
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign wr_ready = !full_q;
  assign rd_valid = full_q;
  assign rd_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= INIT_FULL;
      data_q <= INIT_VAL;
    end else if (wr_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end else if (rd_ready && full_q) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tfir_tap.sv
// One tap: takes a partial sum first, then a sample, writes sample*weight+sum.
module tfir_tap #(
  parameter int            SW     = 8,
  parameter int            CW     = 8,
  parameter int            AW     = 32,
  parameter logic [CW-1:0] WEIGHT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          y_valid,
  input  logic [AW-1:0] y_data,
  output logic          y_ready,
  input  logic          x_valid,
  input  logic [SW-1:0] x_data,
  output logic          x_ready,
  output logic          o_valid,
  output logic [AW-1:0] o_data,
  input  logic          o_ready
);
  logic          have_y_q;
  logic [AW-1:0] y_hold_q;
  logic          fire;

  assign y_ready = !have_y_q;
  assign fire    = have_y_q && x_valid && o_ready;
  assign x_ready = fire;
  assign o_valid = fire;
  assign o_data  = y_hold_q + AW'(x_data) * AW'(WEIGHT);

  always_ff @(posedge clk) begin
    if (rst) begin
      have_y_q <= 1'b0;
      y_hold_q <= '0;
    end else if (!have_y_q && y_valid) begin
      have_y_q <= 1'b1;
      y_hold_q <= y_data;
    end else if (fire) begin
      have_y_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tfir_chain.sv
module tfir_chain #(
  parameter int NTAPS    = 4,
  parameter int SAMPLE_W = tfir_pkg::SAMPLE_W_DEF,
  parameter int COEF_W   = tfir_pkg::COEF_W_DEF,
  parameter int ACC_W    = tfir_pkg::ACC_W_DEF,
  parameter logic [COEF_W-1:0] COEF [NTAPS] = '{8'd3, 8'd1, 8'd4, 8'd2}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [SAMPLE_W-1:0]     s_data,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic signed [ACC_W-1:0] m_data
);
  // partial-sum buffers 0..NTAPS: write side (yw_*) and read side (yr_*)
  logic             yw_v [NTAPS+1];
  logic [ACC_W-1:0] yw_d [NTAPS+1];
  logic             yw_r [NTAPS+1];
  logic             yr_v [NTAPS+1];
  logic [ACC_W-1:0] yr_d [NTAPS+1];
  logic             yr_r [NTAPS+1];
  // sample buffers, one per tap
  logic                xw_r [NTAPS];
  logic                xr_v [NTAPS];
  logic [SAMPLE_W-1:0] xr_d [NTAPS];
  logic                xr_r [NTAPS];
  logic [NTAPS-1:0]    x_empty;
  logic                take;

  always_comb begin
    for (int k = 0; k < NTAPS; k++) x_empty[k] = xw_r[k];
  end
  assign s_ready = &x_empty;
  assign take    = s_valid && s_ready;

  // head buffer refills itself with zero whenever it is empty
  assign yw_v[0] = yw_r[0];
  assign yw_d[0] = '0;

  generate
    for (genvar k = 0; k <= NTAPS; k++) begin : g_ybuf
      tfir_slot #(.W(ACC_W), .INIT_FULL(k < NTAPS), .INIT_VAL('0)) u_ybuf (
        .clk(clk), .rst(rst),
        .wr_valid(yw_v[k]), .wr_data(yw_d[k]), .wr_ready(yw_r[k]),
        .rd_valid(yr_v[k]), .rd_data(yr_d[k]), .rd_ready(yr_r[k]));
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
      tfir_slot #(.W(SAMPLE_W), .INIT_FULL(1'b0), .INIT_VAL('0)) u_xbuf (
        .clk(clk), .rst(rst),
        .wr_valid(take), .wr_data(s_data), .wr_ready(xw_r[k]),
        .rd_valid(xr_v[k]), .rd_data(xr_d[k]), .rd_ready(xr_r[k]));

      tfir_tap #(.SW(SAMPLE_W), .CW(COEF_W), .AW(ACC_W),
                 .WEIGHT(COEF[NTAPS-1-k])) u_tap (
        .clk(clk), .rst(rst),
        .y_valid(yr_v[k]), .y_data(yr_d[k]), .y_ready(yr_r[k]),
        .x_valid(xr_v[k]), .x_data(xr_d[k]), .x_ready(xr_r[k]),
        .o_valid(yw_v[k+1]), .o_data(yw_d[k+1]), .o_ready(yw_r[k+1]));
    end
  endgenerate

  assign yr_r[NTAPS] = m_ready;
  assign m_valid     = yr_v[NTAPS];
  assign m_data      = yr_d[NTAPS];
endmodule

// File: rtl/tfir_chain_chk.sv
module tfir_chain_chk #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    s_valid,
  input logic                    s_ready,
  input logic [SAMPLE_W-1:0]     s_data,
  input logic                    m_valid,
  input logic                    m_ready,
  input logic signed [ACC_W-1:0] m_data
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!m_valid && s_ready));

  p_accept_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  p_out_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready) |=> !m_valid);

  p_known_r2: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !$isunknown(m_data));
endmodule

bind tfir_chain tfir_chain_chk #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/tfir_chain_tb.sv
`timescale 1ns/1ps
module tfir_chain_tb;
  localparam int NT = 4;
  localparam logic [7:0] TB_COEF [NT] = '{8'd3, 8'd1, 8'd4, 8'd2};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic signed [31:0] m_data;

  int n_tests = 0;
  int n_fail  = 0;
  int n_in    = 0;
  int n_out   = 0;
  int hist [NT];
  int exp_q [$];
  bit rand_rdy = 1'b0;

  always #2.5 clk = ~clk;

  tfir_chain #(.NTAPS(NT), .COEF(TB_COEF)) u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // reference model: shift history, weighted sum, push onto scoreboard
  task automatic push_sample(input logic [7:0] x);
    int acc = 0;
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = int'(x);
    for (int k = 0; k < NT; k++) acc += int'(TB_COEF[k]) * hist[k];
    exp_q.push_back(acc);
    n_in++;
  endtask

  task automatic send(input logic [7:0] x);
    s_valid = 1'b1;
    s_data  = x;
    do @(negedge clk); while (!s_ready);
    push_sample(x);
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic stream(input int ncyc, output int nacc);
    nacc = 0;
    s_valid = 1'b1;
    s_data  = 8'($urandom);
    for (int i = 0; i < ncyc; i++) begin
      bit acc_now;
      @(negedge clk);
      acc_now = s_ready;
      if (acc_now) begin push_sample(s_data); nacc++; end
      @(posedge clk); #1;
      if (acc_now) s_data = 8'($urandom);
    end
    s_valid = 1'b0;
  endtask

  // scoreboard monitor (R2, R3, R7)
  always @(negedge clk) begin
    if (!rst && m_valid && m_ready) begin
      n_out++;
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected result", m_data, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(m_data == e, "R2/R3/R7 result value", m_data, e);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rand_rdy) m_ready = 1'($urandom);
  end

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int nacc;
    logic signed [31:0] held;
    for (int k = 0; k < NT; k++) hist[k] = 0;
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    check(m_valid == 1'b0, "R1 m_valid after reset", m_valid, 0);
    check(s_ready == 1'b1, "R1 s_ready after reset", s_ready, 1);
    @(posedge clk); #1;

    // R4 latency and R3 impulse response
    s_valid = 1'b1; s_data = 8'd1;
    @(negedge clk);
    check(s_ready == 1'b1, "R4 ready when idle", s_ready, 1);
    push_sample(8'd1);
    @(posedge clk); #1; s_valid = 1'b0;
    @(negedge clk);
    check(m_valid == 1'b0, "R4 not yet valid", m_valid, 0);
    check(s_ready == 1'b0, "R5 ready low after accept", s_ready, 0);
    @(negedge clk);
    check(m_valid == 1'b1, "R4 valid one cycle after accept", m_valid, 1);
    check(m_data == 32'sd3, "R3 first impulse term", m_data, 3);
    @(posedge clk); #1;
    for (int i = 0; i < NT - 1; i++) send(8'd0);
    repeat (10) @(posedge clk); #1;

    // R2 full-scale samples
    for (int i = 0; i < 6; i++) send(8'd255);
    repeat (10) @(posedge clk); #1;

    // R5 rate under continuous input
    stream(40, nacc);
    check(nacc == 20, "R5 accepts in 40 cycles", nacc, 20);
    repeat (10) @(posedge clk); #1;

    // R6 stall: output held, input blocked
    m_ready = 1'b0;
    stream(30, nacc);
    @(negedge clk);
    check(s_ready == 1'b0, "R6 input blocked when full", s_ready, 0);
    check(m_valid == 1'b1, "R6 valid held", m_valid, 1);
    held = m_data;
    repeat (5) @(negedge clk);
    check(m_valid == 1'b1, "R6 valid still held", m_valid, 1);
    check(m_data == held, "R6 data stable", m_data, held);
    @(posedge clk); #1;
    m_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(m_valid == 1'b0, "R8 gap after transfer", m_valid, 0);
    repeat (40) @(posedge clk); #1;

    // R7 random backpressure
    rand_rdy = 1'b1;
    for (int i = 0; i < 60; i++) send(8'($urandom));
    repeat (300) @(posedge clk);
    rand_rdy = 1'b0; #1; m_ready = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    check(n_out == n_in, "R7 result count", n_out, n_in);
    finish_run();
  end
endmodule